// File: doc/BRIEF.md
# Receive Buffer with Fill-Level Flow Control

This block sits between a UART receiver and the CPU bus. It queues received characters and hands them out in arrival order. Each queued entry holds an 8-bit character and three error-status flags, which tell whether the character had a parity error, a framing error or a break condition. The oldest entry and its flags are always visible on the read port. A DMA-ready output is high whenever at least one character is waiting.

When automatic flow control is enabled, the block drives the request-to-send line from its own fill level. Once the fill level reaches a selectable trigger depth, the line drops, which asks the remote sender to pause. The line stays low until the buffer has been fully drained. If a character arrives while every slot is taken and nothing leaves in that cycle, the character is discarded and a sticky overrun flag is raised. That flag stays set until the CPU signals that it has read it.

Top module: `rx_flow_fifo`

## Requirements
- R1: After reset the buffer is empty: `rx_ready` is 0, `rts` is 1 and `overrun` is 0.
- R2: Up to DEPTH (default 16) entries are accepted, and reads return them in write order.
- R3: Each entry stores `wr_err` with its byte, and `rd_err` shows the head entry's flags next to `rd_data`. The flag bits are: bit 0 parity, bit 1 framing, bit 2 break.
- R4: `rx_ready` is 1 exactly when the buffer holds at least one entry, as seen after the clock edge that changes the fill level.
- R5: A write into a full buffer with no read in the same cycle is dropped, and the stored contents are left unchanged.
- R6: A dropped write sets `overrun` on the same edge. `overrun` holds until a cycle with `ovr_ack` high clears it. When a drop and an `ovr_ack` occur in the same cycle, the flag is set.
- R7: A read of an empty buffer is ignored, and a later write is still read back correctly.
- R8: `trig_sel` selects the trigger depth: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 14.
- R9: With `flow_en` high, `rts` falls on the edge where the fill level becomes at least the trigger depth. After that it stays low until the edge that empties the buffer, and on that edge it returns to 1.
- R10: With `flow_en` low, `rts` is 1 after the next edge, whatever the fill level.
- R11: A read and a write in the same cycle on a full buffer both take effect, and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Receiver pushes one character |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Flags for the character: bit 0 parity, bit 1 framing, bit 2 break |
| rd_en | input | 1 | CPU pops the head entry |
| rd_data | output | 8 | Head character |
| rd_err | output | 3 | Head entry flags |
| rx_ready | output | 1 | At least one entry is waiting (DMA request) |
| flow_en | input | 1 | Enables automatic request-to-send control |
| trig_sel | input | 2 | Trigger depth select |
| rts | output | 1 | Request-to-send, high means the sender may transmit |
| ovr_ack | input | 1 | CPU has read the overrun status, which clears it |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default parameters: a depth of 16 and trigger depths of 1, 4, 8 and 14. With these values, the full-buffer cases (drop, overrun, simultaneous read and write at full) and all four trigger points, including the one at 14 just below full, can be reached within a few dozen cycles. A short depth of 16 also lets the bench walk the whole queue in order, checking every entry's flags.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    // Error flag positions within an entry's status field
    localparam int ERR_PARITY = 0;
    localparam int ERR_FRAME  = 1;
    localparam int ERR_BREAK  = 2;
    localparam int ERR_W      = 3;

    typedef enum logic [1:0] {
        TRIG_LVL0 = 2'd0,
        TRIG_LVL1 = 2'd1,
        TRIG_LVL2 = 2'd2,
        TRIG_LVL3 = 2'd3
    } trig_sel_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int EW    = 11,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [EW-1:0] rdata
);
    logic [EW-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [EW-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[i];
            if (we && (waddr == PW'(i))) slot_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d;
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/rxf_rts.sv
module rxf_rts #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow_en,
    input  logic [CW-1:0] level_nxt,
    input  logic [CW-1:0] thresh,
    output logic          rts
);
    logic rts_d, rts_q;

    always_comb begin
        rts_d = rts_q;
        if (!flow_en)                 rts_d = 1'b1;
        else if (level_nxt >= thresh) rts_d = 1'b0;
        else if (level_nxt == '0)     rts_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rts_q <= 1'b1;
        else        rts_q <= rts_d;
    end

    assign rts = rts_q;

    // R10: flow control off forces request-to-send high
    a_r10_flow_off: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |=> rts_q);
    // R9: low line stays low until the buffer is empty
    a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && !rts_q && level_nxt != '0) |=> !rts_q);
endmodule

// File: rtl/rx_flow_fifo.sv
module rx_flow_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int TRIG0  = 1,
    parameter int TRIG1  = 4,
    parameter int TRIG2  = 8,
    parameter int TRIG3  = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [rxf_pkg::ERR_W-1:0] wr_err,
    input  logic                     rd_en,
    output logic [DATA_W-1:0]        rd_data,
    output logic [rxf_pkg::ERR_W-1:0] rd_err,
    output logic                     rx_ready,
    input  logic                     flow_en,
    input  logic [1:0]               trig_sel,
    output logic                     rts,
    input  logic                     ovr_ack,
    output logic                     overrun
);
    import rxf_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = DATA_W + ERR_W;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          pop, push, drop;
    logic [CW-1:0] thresh;
    logic [EW-1:0] head;

    always_comb begin
        pop   = rd_en && (ctl_q.cnt != '0);
        push  = wr_en && ((ctl_q.cnt != FULL) || pop);
        drop  = wr_en && !push;

        ctl_d = ctl_q;
        if (push) ctl_d.wp = (ctl_q.wp == LAST) ? '0 : ctl_q.wp + 1'b1;
        if (pop)  ctl_d.rp = (ctl_q.rp == LAST) ? '0 : ctl_q.rp + 1'b1;
        case ({push, pop})
            2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
            2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
        ctl_d.ovr = drop || (ctl_q.ovr && !ovr_ack);

        case (trig_sel_e'(trig_sel))
            TRIG_LVL0: thresh = CW'(TRIG0);
            TRIG_LVL1: thresh = CW'(TRIG1);
            TRIG_LVL2: thresh = CW'(TRIG2);
            default:   thresh = CW'(TRIG3);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rxf_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push),
        .waddr (ctl_q.wp),
        .wdata ({wr_err, wr_data}),
        .raddr (ctl_q.rp),
        .rdata (head)
    );

    rxf_rts #(.CW(CW)) u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_en   (flow_en),
        .level_nxt (ctl_d.cnt),
        .thresh    (thresh),
        .rts       (rts)
    );

    assign rd_data  = head[DATA_W-1:0];
    assign rd_err   = head[EW-1:DATA_W];
    assign rx_ready = (ctl_q.cnt != '0);
    assign overrun  = ctl_q.ovr;

    // R2: fill level never exceeds the depth
    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= FULL);
    // R5: a write into a full buffer without a read leaves the level alone and flags overrun
    a_r5_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && ctl_q.cnt == FULL) |=> (overrun && ctl_q.cnt == FULL));
    // R6: overrun is sticky until acknowledged
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_ack) |=> overrun);
    // R7: a read of an empty buffer changes nothing
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && rd_en && !wr_en) |=> !rx_ready);
    // R11: read and write together at full keep the buffer full and raise no overrun
    a_r11_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && ctl_q.cnt == FULL && !overrun) |=> (!overrun && ctl_q.cnt == FULL));
endmodule

// File: tb/tb_rx_flow_fifo.sv
module tb_rx_flow_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, flow_en = 1'b0, ovr_ack = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_err = '0;
    logic [1:0] trig_sel = '0;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic       rx_ready, rts, overrun;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rx_flow_fifo dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
        .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err), .rx_ready(rx_ready),
        .flow_en(flow_en), .trig_sel(trig_sel), .rts(rts), .ovr_ack(ovr_ack),
        .overrun(overrun)
    );

    // wr rd ack flow trig data err | rdy rts ovr head_data head_err
    localparam int NV = 20;
    localparam logic [30:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b1,2'd1,8'hA1,3'd0, 1'b1,1'b1,1'b0,8'hA1,3'd0},
        {1'b1,1'b0,1'b0,1'b1,2'd1,8'hB2,3'd1, 1'b1,1'b1,1'b0,8'hA1,3'd0},
        {1'b1,1'b0,1'b0,1'b1,2'd1,8'hC3,3'd2, 1'b1,1'b1,1'b0,8'hA1,3'd0},
        {1'b1,1'b0,1'b0,1'b1,2'd1,8'hD4,3'd4, 1'b1,1'b0,1'b0,8'hA1,3'd0},
        {1'b0,1'b1,1'b0,1'b1,2'd1,8'h00,3'd0, 1'b1,1'b0,1'b0,8'hB2,3'd1},
        {1'b0,1'b1,1'b0,1'b1,2'd1,8'h00,3'd0, 1'b1,1'b0,1'b0,8'hC3,3'd2},
        {1'b1,1'b1,1'b0,1'b1,2'd1,8'hE5,3'd3, 1'b1,1'b0,1'b0,8'hD4,3'd4},
        {1'b0,1'b1,1'b0,1'b1,2'd1,8'h00,3'd0, 1'b1,1'b0,1'b0,8'hE5,3'd3},
        {1'b0,1'b1,1'b0,1'b1,2'd1,8'h00,3'd0, 1'b0,1'b1,1'b0,8'h00,3'd0},
        {1'b0,1'b1,1'b0,1'b1,2'd1,8'h00,3'd0, 1'b0,1'b1,1'b0,8'h00,3'd0},
        {1'b1,1'b0,1'b0,1'b1,2'd1,8'h5A,3'd0, 1'b1,1'b1,1'b0,8'h5A,3'd0},
        {1'b1,1'b0,1'b0,1'b0,2'd1,8'h6B,3'd1, 1'b1,1'b1,1'b0,8'h5A,3'd0},
        {1'b1,1'b0,1'b0,1'b0,2'd1,8'h7C,3'd2, 1'b1,1'b1,1'b0,8'h5A,3'd0},
        {1'b1,1'b0,1'b0,1'b1,2'd1,8'h8D,3'd7, 1'b1,1'b0,1'b0,8'h5A,3'd0},
        {1'b0,1'b0,1'b0,1'b0,2'd1,8'h00,3'd0, 1'b1,1'b1,1'b0,8'h5A,3'd0},
        {1'b0,1'b0,1'b0,1'b1,2'd1,8'h00,3'd0, 1'b1,1'b0,1'b0,8'h5A,3'd0},
        {1'b0,1'b1,1'b0,1'b1,2'd1,8'h00,3'd0, 1'b1,1'b0,1'b0,8'h6B,3'd1},
        {1'b0,1'b1,1'b0,1'b1,2'd1,8'h00,3'd0, 1'b1,1'b0,1'b0,8'h7C,3'd2},
        {1'b0,1'b1,1'b0,1'b1,2'd1,8'h00,3'd0, 1'b1,1'b0,1'b0,8'h8D,3'd7},
        {1'b0,1'b1,1'b0,1'b1,2'd1,8'h00,3'd0, 1'b0,1'b1,1'b0,8'h00,3'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample 1 ns later
    task automatic step(input logic w, input logic r, input logic a,
                        input logic [7:0] d, input logic [2:0] e);
        @(negedge clk);
        wr_en = w; rd_en = r; ovr_ack = a; wr_data = d; wr_err = e;
        @(posedge clk);
        #1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; ovr_ack = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; ovr_ack = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(50000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 rx_ready", rx_ready, 0);
        check("R1 rts", rts, 1);
        check("R1 overrun", overrun, 0);

        // Table walk: R2/R3/R4/R7/R9/R10 with trigger depth 4
        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = VEC[i];
            flow_en  = v[27];
            trig_sel = v[26:25];
            step(v[30], v[29], v[28], v[24:17], v[16:14]);
            check($sformatf("R4 vec%0d rx_ready", i), rx_ready, v[13]);
            check($sformatf("R9/R10 vec%0d rts", i), rts, v[12]);
            check($sformatf("R6 vec%0d overrun", i), overrun, v[11]);
            if (v[13])
                check($sformatf("R2/R3 vec%0d head", i), {rd_data, rd_err}, {v[10:3], v[2:0]});
        end

        // R8: each trigger depth
        for (int s = 0; s < 4; s++) begin
            int thr;
            thr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            do_reset();
            flow_en = 1'b1;
            trig_sel = 2'(s);
            for (int k = 1; k <= thr; k++) begin
                step(1'b1, 1'b0, 1'b0, 8'(k), 3'd0);
                check($sformatf("R8 sel%0d fill%0d rts", s, k), rts, (k < thr) ? 1 : 0);
            end
            for (int k = thr; k > 0; k--) begin
                step(1'b0, 1'b1, 1'b0, 8'h00, 3'd0);
                check($sformatf("R9 sel%0d left%0d rts", s, k - 1), rts, (k == 1) ? 1 : 0);
            end
        end

        // Full buffer: R5, R6, R11, then in-order drain R2/R3
        do_reset();
        flow_en = 1'b1;
        trig_sel = 2'd3;
        for (int k = 0; k < 16; k++) step(1'b1, 1'b0, 1'b0, 8'(k * 17 + 3), 3'(k % 8));
        check("R5 full overrun clear before drop", overrun, 0);
        step(1'b1, 1'b0, 1'b0, 8'hEE, 3'd7);
        check("R5 drop sets overrun", overrun, 1);
        check("R5 head unchanged", {rd_data, rd_err}, {8'd3, 3'd0});
        step(1'b0, 1'b0, 1'b0, 8'h00, 3'd0);
        check("R6 overrun sticky", overrun, 1);
        step(1'b1, 1'b0, 1'b1, 8'hEF, 3'd7);
        check("R6 drop wins over ack", overrun, 1);
        step(1'b0, 1'b0, 1'b1, 8'h00, 3'd0);
        check("R6 ack clears", overrun, 0);
        step(1'b1, 1'b1, 1'b0, 8'h99, 3'd5);
        check("R11 no overrun on swap", overrun, 0);
        check("R11 head advanced", {rd_data, rd_err}, {8'd20, 3'd1});
        for (int k = 1; k < 16; k++) begin
            check($sformatf("R2/R3 drain%0d", k), {rd_data, rd_err}, {8'(k * 17 + 3), 3'(k % 8)});
            step(1'b0, 1'b1, 1'b0, 8'h00, 3'd0);
        end
        check("R11 swapped entry last", {rd_data, rd_err}, {8'h99, 3'd5});
        check("R5 dropped entries absent", rx_ready, 1);
        step(1'b0, 1'b1, 1'b0, 8'h00, 3'd0);
        check("R4 empty after drain", rx_ready, 0);
        check("R9 rts back high", rts, 1);

        // R7: empty read then write
        step(1'b0, 1'b1, 1'b0, 8'h00, 3'd0);
        check("R7 empty read ignored", rx_ready, 0);
        step(1'b1, 1'b0, 1'b0, 8'h42, 3'd6);
        check("R7 write after empty read", {rx_ready, rd_data, rd_err}, {1'b1, 8'h42, 3'd6});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule